// File: doc/BRIEF.md
# Serial Controller Register Bank

This block is the CPU-facing side of a byte-stream serial controller. Software reaches it over a simple single-cycle bus with a word index, a four-bit byte enable and 32-bit data. It holds line-control, line-status, interrupt-enable, interrupt-status, FIFO-control and baud-generator words. Every writable word applies its own mask of writable bits, so only the defined fields hold state. A transmit FIFO and a receive FIFO sit between the bus and an external bit-level serializer. The serializer pulls transmit bytes over a valid/ready stream and delivers received bytes over a second stream.

Hardware sets the interrupt-status flags from FIFO occupancy. Software clears them by writing a value that is ANDed into the stored lanes. A single level interrupt output reports any status flag whose enable bit is set. Software loads the transmit FIFO by writing the most significant byte lane of the transmit window. It drains the receive FIFO by reading the most significant byte lane of the receive window. A flush of either FIFO is requested through the FIFO-control word, and only takes effect when the flush-enable bit is set in the same written value.

Top module: `sio_regbank`

## Requirements
- R1: While reset is held and right after it, line control reads 0x40000000, baud generator reads 0x03FF0000, every other word reads 0x00000000, and both FIFOs are empty (tx_valid low).
- R2: The word index selects the following words: 0 line control, 1 line status, 2 interrupt enable, 3 interrupt status, 4 FIFO control, 5 baud generator, 8 transmit window, 12 receive window. Any other index reads zero, and writes to it change nothing. The transmit window reads zero.
- R3: A write keeps only the writable bits: 0xE17F0000 for line control, 0x000F0000 for interrupt enable, 0x00070000 for interrupt status, 0x001F0000 for FIFO control, 0x03FF0000 for baud generator. Writes to line status are ignored.
- R4: Byte enable bit k selects bits [31-8k : 24-8k], so bit 0 selects bits 31:24. Lanes that are not enabled keep their stored value.
- R5: Interrupt-status bit 16 is set on the clock after the receive FIFO holds data. Bit 17 is set on the clock after the transmit FIFO is empty. Both flags stay set until software clears them.
- R6: A write to interrupt status replaces each enabled lane with the stored lane ANDed with the written byte, then applies the mask. A flag whose condition still holds is set again on the next clock.
- R7: irq is high exactly when interrupt status bits 18:16 ANDed with interrupt-enable bits 18:16 are not all zero. Enable bit 18 is error, bit 17 transmit-empty, bit 16 receive-available.
- R8: In FIFO control, bit 16 is flush enable, bit 17 flushes the receive FIFO and bit 18 flushes the transmit FIFO. The flush happens on the write itself, and only when bit 16 is also set in the updated value. The bits read back as stored.
- R9: A write to the transmit window pushes bits 31:24 only when byte enable bit 0 is set. Bytes leave on tx_data/tx_valid in write order, one per cycle in which tx_ready is high.
- R10: A read of the receive window with byte enable bit 0 set and a non-empty receive FIFO returns the oldest byte in bits 31:24, with zeros elsewhere, and removes that byte. In every other case the read returns zero and removes nothing.
- R11: Each FIFO holds FIFO_DEPTH bytes (default 16), and rx_ready is low while the receive FIFO is full. A byte pushed into a full FIFO is dropped: a CPU write into a full transmit FIFO, or rx_valid while rx_ready is low. Either event sets line-status bit 0, which stays set until reset.
- R12: Interrupt-enable bit 19 (DMA request) is stored and read back but never drives irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_widx | input | ADDR_W (6) | Word index within the 0x100-byte window |
| bus_be | input | 4 | Byte enables, bit 0 is bits 31:24 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Level interrupt |
| tx_data | output | 8 | Byte toward the serializer |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Serializer takes the byte |
| rx_data | input | 8 | Byte from the serializer |
| rx_valid | input | 1 | Received byte presented |
| rx_ready | output | 1 | Receive FIFO has room |

## Verification
The bench builds the block with FIFO_DEPTH set to 4, so both the full receive FIFO and the dropped byte that sets the overrun bit come up after a handful of pushes. The FIFO ordering, the masked lane merge and the AND-clear of the status flags do not depend on depth, and they are covered the same way at that size. ADDR_W stays at 6, so the window decode runs exactly as it does at the default.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int unsigned WORD_W = 32;

  // word indices within the register window
  localparam int unsigned IX_LINE  = 0;
  localparam int unsigned IX_LSTAT = 1;
  localparam int unsigned IX_IEN   = 2;
  localparam int unsigned IX_ISTAT = 3;
  localparam int unsigned IX_FCTL  = 4;
  localparam int unsigned IX_BAUD  = 5;
  localparam int unsigned IX_TXQ   = 8;
  localparam int unsigned IX_RXQ   = 12;

  localparam logic [31:0] LINE_WMASK  = 32'hE17F_0000;
  localparam logic [31:0] IEN_WMASK   = 32'h000F_0000;
  localparam logic [31:0] ISTAT_WMASK = 32'h0007_0000;
  localparam logic [31:0] FCTL_WMASK  = 32'h001F_0000;
  localparam logic [31:0] BAUD_WMASK  = 32'h03FF_0000;
  localparam logic [31:0] IRQ_SRC     = 32'h0007_0000;

  localparam logic [31:0] LINE_RST = 32'h4000_0000;
  localparam logic [31:0] BAUD_RST = 32'h03FF_0000;

  localparam int unsigned ST_RXAV  = 16;
  localparam int unsigned ST_TXMT  = 17;
  localparam int unsigned FC_ARM   = 16;
  localparam int unsigned FC_RXFL  = 17;
  localparam int unsigned FC_TXFL  = 18;

  // expand byte enables to a bit mask, enable bit 0 covers bits 31:24
  function automatic logic [31:0] lane_bits(input logic [3:0] be);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[31-8*k -: 8] = {8{be[k]}};
    return m;
  endfunction

  function automatic logic [31:0] lane_merge(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  be,
                                             input logic [31:0] wmask);
    logic [31:0] m;
    m = lane_bits(be);
    return wmask & ((old_w & ~m) | (new_w & m));
  endfunction
endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic         drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign drop    = push & full & ~flush;
  assign dout    = mem[rd_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = bump(wr_q);
      if (do_pop)  rd_d = bump(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end
endmodule

// File: rtl/sio_intc.sv
module sio_intc
  import sio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_we,
  input  logic        st_we,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  input  logic        rx_avail,
  input  logic        tx_empty,
  output logic [31:0] en_q,
  output logic [31:0] st_q,
  output logic        irq
);
  logic [31:0] en_d, st_d, st_clr, lm;

  assign lm = lane_bits(be);

  always_comb begin
    en_d = en_we ? lane_merge(en_q, wdata, be, IEN_WMASK) : en_q;
    // software clear first: stored lane ANDed with written byte
    st_clr = st_we ? (ISTAT_WMASK & ((st_q & ~lm) | (st_q & wdata & lm))) : st_q;
    // hardware set from current occupancy wins over the clear
    st_d = st_clr;
    if (rx_avail) st_d[ST_RXAV] = 1'b1;
    if (tx_empty) st_d[ST_TXMT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      en_q <= en_d;
      st_q <= st_d;
    end
  end

  assign irq = |(st_q & en_q & IRQ_SRC);
endmodule

// File: rtl/sio_regbank.sv
module sio_regbank
  import sio_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int ADDR_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_widx,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_ready
);
  logic wr, rd;
  logic hit_line, hit_lstat, hit_ien, hit_istat, hit_fctl, hit_baud, hit_txq, hit_rxq;
  logic [31:0] line_q, line_d, baud_q, baud_d, fctl_q, fctl_d;
  logic        ovr_q, ovr_d;
  logic [31:0] ien_q, ist_q;
  logic        tx_push, tx_pop, tx_empty, tx_full, tx_drop, tx_flush;
  logic        rx_pop, rx_empty, rx_full, rx_drop, rx_flush;
  logic [7:0]  rx_head;
  logic        fctl_wr;

  assign wr = bus_sel & bus_we;
  assign rd = bus_sel & ~bus_we;

  assign hit_line  = (bus_widx == ADDR_W'(IX_LINE));
  assign hit_lstat = (bus_widx == ADDR_W'(IX_LSTAT));
  assign hit_ien   = (bus_widx == ADDR_W'(IX_IEN));
  assign hit_istat = (bus_widx == ADDR_W'(IX_ISTAT));
  assign hit_fctl  = (bus_widx == ADDR_W'(IX_FCTL));
  assign hit_baud  = (bus_widx == ADDR_W'(IX_BAUD));
  assign hit_txq   = (bus_widx == ADDR_W'(IX_TXQ));
  assign hit_rxq   = (bus_widx == ADDR_W'(IX_RXQ));

  assign fctl_wr  = wr & hit_fctl;
  assign tx_push  = wr & hit_txq & bus_be[0];
  assign rx_pop   = rd & hit_rxq & bus_be[0];
  assign tx_pop   = tx_valid & tx_ready;
  assign tx_valid = ~tx_empty;
  assign rx_ready = ~rx_full;

  always_comb begin
    line_d = (wr & hit_line) ? lane_merge(line_q, bus_wdata, bus_be, LINE_WMASK) : line_q;
    baud_d = (wr & hit_baud) ? lane_merge(baud_q, bus_wdata, bus_be, BAUD_WMASK) : baud_q;
    fctl_d = fctl_wr ? lane_merge(fctl_q, bus_wdata, bus_be, FCTL_WMASK) : fctl_q;
    ovr_d  = ovr_q | tx_drop | rx_drop;
  end

  assign rx_flush = fctl_wr & fctl_d[FC_ARM] & fctl_d[FC_RXFL];
  assign tx_flush = fctl_wr & fctl_d[FC_ARM] & fctl_d[FC_TXFL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= LINE_RST;
      baud_q <= BAUD_RST;
      fctl_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      line_q <= line_d;
      baud_q <= baud_d;
      fctl_q <= fctl_d;
      ovr_q  <= ovr_d;
    end
  end

  sio_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(tx_push), .din(bus_wdata[31:24]), .pop(tx_pop),
    .dout(tx_data), .empty(tx_empty), .full(tx_full), .drop(tx_drop)
  );

  sio_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(rx_valid), .din(rx_data), .pop(rx_pop),
    .dout(rx_head), .empty(rx_empty), .full(rx_full), .drop(rx_drop)
  );

  sio_intc u_intc (
    .clk(clk), .rst_n(rst_n),
    .en_we(wr & hit_ien), .st_we(wr & hit_istat),
    .be(bus_be), .wdata(bus_wdata),
    .rx_avail(~rx_empty), .tx_empty(tx_empty),
    .en_q(ien_q), .st_q(ist_q), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      unique case (1'b1)
        hit_line:  bus_rdata = line_q;
        hit_lstat: bus_rdata = {31'b0, ovr_q};
        hit_ien:   bus_rdata = ien_q;
        hit_istat: bus_rdata = ist_q;
        hit_fctl:  bus_rdata = fctl_q;
        hit_baud:  bus_rdata = baud_q;
        hit_rxq:   bus_rdata = (bus_be[0] & ~rx_empty) ? {rx_head, 24'h0} : '0;
        default:   bus_rdata = '0;
      endcase
    end
  end

  logic unused_ok;
  assign unused_ok = tx_full;
endmodule

// File: rtl/sio_regbank_chk.sv
module sio_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        tx_flush,
  input logic        ovr,
  input logic [31:0] ist,
  input logic [31:0] ien,
  input logic        irq,
  input logic        rx_rd_msb,
  input logic        rx_empty,
  input logic [31:0] rdata
);
  // R11
  rx_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> ovr);

  // R11
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> ovr);

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !tx_flush |=> tx_valid && $stable(tx_data));

  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ist[17:16] & ien[17:16]) != 2'b00) |-> irq);

  // R12
  dma_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien[18:16] != 3'b000));

  // R10
  rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd_msb && rx_empty |-> rdata == 32'h0);
endmodule

bind sio_regbank sio_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .rx_valid(rx_valid), .rx_ready(rx_ready),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_flush(tx_flush), .ovr(ovr_q), .ist(ist_q), .ien(ien_q), .irq(irq),
  .rx_rd_msb(rx_pop), .rx_empty(rx_empty), .rdata(bus_rdata)
);

// File: tb/sio_regbank_test.sv
module sio_regbank_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic        clk, rst_n;
  logic        bus_sel, bus_we;
  logic [5:0]  bus_widx;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq, tx_valid, tx_ready, rx_valid, rx_ready;
  logic [7:0]  tx_data, rx_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] exp_q[$];

  sio_regbank #(.FIFO_DEPTH(DEPTH), .ADDR_W(6)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_widx(bus_widx), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic rd(input int idx, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_widx = 6'(idx); bus_be = be;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic wr(input int idx, input logic [3:0] be, input logic [31:0] v);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_widx = 6'(idx); bus_be = be; bus_wdata = v;
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0;
  endtask

  // driver: pushes the byte and records it for the scoreboard
  task automatic send_tx(input logic [7:0] b);
    wr(8, 4'b0001, {b, 24'h00_0000});
    exp_q.push_back(b);
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    @(posedge clk); #1;
    rx_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: compares each transmit handshake with the scoreboard
  always @(negedge clk) begin
    #1;
    if (rst_n && tx_valid && tx_ready) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R9: actual %02h expected no byte", tx_data);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (tx_data !== e) begin
          n_fail++;
          $display("FAIL R9: actual %02h expected %02h", tx_data, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 0; bus_sel = 0; bus_we = 0; bus_widx = 0; bus_be = 0; bus_wdata = 0;
    tx_ready = 0; rx_valid = 0; rx_data = 0;
    idle(2);
    // R1 reset values read during reset
    rd(0, 4'hF, d);  chk(d, 32'h4000_0000, "R1 line");
    rd(5, 4'hF, d);  chk(d, 32'h03FF_0000, "R1 baud");
    rd(1, 4'hF, d);  chk(d, 32'h0, "R1 lstat");
    rd(2, 4'hF, d);  chk(d, 32'h0, "R1 ien");
    rd(3, 4'hF, d);  chk(d, 32'h0, "R1 istat");
    rd(4, 4'hF, d);  chk(d, 32'h0, "R1 fctl");
    chk({31'b0, tx_valid}, 32'h0, "R1 tx empty");
    @(negedge clk); rst_n = 1;
    idle(2);
    // R5 transmit-empty flag from empty FIFO
    rd(3, 4'hF, d);  chk(d, 32'h0002_0000, "R5 txmt");
    // R3 write masks
    wr(0, 4'hF, 32'hFFFF_FFFF); rd(0, 4'hF, d); chk(d, 32'hE17F_0000, "R3 line");
    wr(5, 4'hF, 32'hFFFF_FFFF); rd(5, 4'hF, d); chk(d, 32'h03FF_0000, "R3 baud");
    wr(4, 4'hF, 32'hFFFF_FFFF); rd(4, 4'hF, d); chk(d, 32'h001F_0000, "R3 fctl");
    wr(1, 4'hF, 32'hFFFF_FFFF); rd(1, 4'hF, d); chk(d, 32'h0, "R3 lstat ro");
    wr(2, 4'hF, 32'hFFFF_FFFF); rd(2, 4'hF, d); chk(d, 32'h000F_0000, "R3 ien");
    @(negedge clk); #1 chk({31'b0, irq}, 32'h1, "R7 irq on");
    wr(2, 4'hF, 32'h0); wr(4, 4'hF, 32'h0);
    @(negedge clk); #1 chk({31'b0, irq}, 32'h0, "R7 irq off");
    // R4 byte lanes
    wr(0, 4'hF, 32'h0);
    wr(0, 4'b0001, 32'hFFFF_FFFF); rd(0, 4'hF, d); chk(d, 32'hE100_0000, "R4 lane0");
    wr(0, 4'b0100, 32'hFFFF_FFFF); rd(0, 4'hF, d); chk(d, 32'hE100_0000, "R4 lane2");
    wr(0, 4'b0010, 32'hFFFF_FFFF); rd(0, 4'hF, d); chk(d, 32'hE17F_0000, "R4 lane1");
    // R2 unmapped and transmit window reads
    wr(7, 4'hF, 32'hFFFF_FFFF);
    rd(7, 4'hF, d);  chk(d, 32'h0, "R2 unmapped");
    rd(0, 4'hF, d);  chk(d, 32'hE17F_0000, "R2 unmapped write");
    rd(8, 4'hF, d);  chk(d, 32'h0, "R2 txq read");
    // R9 transmit lane rule and ordering
    send_tx(8'h41);
    wr(8, 4'b1000, 32'h0000_0042);
    send_tx(8'h43);
    // R6 clear by AND on lane 1
    wr(3, 4'b0010, 32'h0);
    rd(3, 4'hF, d);  chk(d, 32'h0, "R6 clear");
    wr(2, 4'hF, 32'h0002_0000);
    @(negedge clk); #1 chk({31'b0, irq}, 32'h0, "R7 masked idle");
    @(negedge clk); tx_ready = 1;
    idle(5);
    chk(32'(exp_q.size()), 32'h0, "R9 drained");
    chk({31'b0, tx_valid}, 32'h0, "R9 lane3 ignored");
    chk({31'b0, irq}, 32'h1, "R7 txmt irq");
    // R12 DMA bit stored only
    wr(2, 4'hF, 32'h0008_0000);
    rd(2, 4'hF, d);  chk(d, 32'h0008_0000, "R12 stored");
    chk({31'b0, irq}, 32'h0, "R12 no irq");
    wr(2, 4'hF, 32'h0);
    // R10 receive reads
    rd(12, 4'b0001, d); chk(d, 32'h0, "R10 empty");
    push_rx(8'h5A); push_rx(8'hA5);
    idle(1);
    rd(3, 4'hF, d);  chk(d, 32'h0003_0000, "R5 rxav");
    rd(12, 4'b0010, d); chk(d, 32'h0, "R10 lane1");
    rd(12, 4'b0001, d); chk(d, 32'h5A00_0000, "R10 first");
    rd(12, 4'b0001, d); chk(d, 32'hA500_0000, "R10 second");
    rd(12, 4'b0001, d); chk(d, 32'h0, "R10 drained");
    // R11 full receive FIFO and overrun
    for (int i = 0; i < DEPTH; i++) push_rx(8'(8'h10 + i));
    @(negedge clk); #1 chk({31'b0, rx_ready}, 32'h0, "R11 rx_ready");
    rd(1, 4'hF, d);  chk(d, 32'h0, "R11 no ovr");
    push_rx(8'h99);
    rd(1, 4'hF, d);  chk(d, 32'h1, "R11 ovr");
    for (int i = 0; i < DEPTH; i++) begin
      rd(12, 4'b0001, d); chk(d, {8'(8'h10 + i), 24'h0}, "R11 order");
    end
    rd(12, 4'b0001, d); chk(d, 32'h0, "R11 dropped");
    rd(1, 4'hF, d);  chk(d, 32'h1, "R11 sticky");
    // R8 flush control
    push_rx(8'h21); push_rx(8'h22);
    wr(4, 4'hF, 32'h0002_0000);
    rd(12, 4'b0001, d); chk(d, 32'h2100_0000, "R8 unarmed");
    wr(4, 4'hF, 32'h0003_0000);
    rd(4, 4'hF, d);  chk(d, 32'h0003_0000, "R8 readback");
    rd(12, 4'b0001, d); chk(d, 32'h0, "R8 rx flushed");
    @(negedge clk); tx_ready = 0;
    send_tx(8'hAA); send_tx(8'hBB);
    wr(4, 4'hF, 32'h0005_0000);
    exp_q.delete();
    @(negedge clk); #1 chk({31'b0, tx_valid}, 32'h0, "R8 tx flushed");
    tx_ready = 1;
    idle(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule